// File: doc/BRIEF.md
# Configuration Register Target with Read-Only Protection

This block is the responding side of a configuration-management handshake. A requester presents a Dword address, a function number and either a read strobe or a write strobe. The block holds a bank of 32-bit registers for each function and answers every request with a single completion pulse. The pulse comes a fixed, parameterized number of cycles after the block accepts the request. When a read completes, the whole addressed register appears on the read-data output during the pulse.

Writes merge the write data into the register under two masks. One mask comes from the four byte enables. The other is a fixed read-only mask that each register carries. A plain write never changes a read-only bit. In root-port mode, a write that also carries the debug-access flag may change read-only bits, but still only within the enabled bytes. The storage is 16 Dwords for each of 2 functions. Any request outside that range completes normally: a read returns zero and a write changes nothing.

The requester holds its strobe and request fields steady until it sees completion. It drops the strobe in the cycle after completion. The block treats a strobe that is still high while completion is showing as the tail of the finished request, not as a new one.

Top module: `cfg_space_target`

## Requirements
- R1: After reset, `rsp_done` is low. Register k of function f reads as {8'hC0+f, k[7:0], 16'hA5A5}.
- R2: A strobe is accepted at a clock edge where the block is idle. `rsp_done` rises exactly LATENCY edges after the accepting edge (default 3, minimum 1). The request fields are captured at the accepting edge.
- R3: `rsp_done` is high for exactly one cycle per accepted request.
- R4: A write updates only the bytes whose enable is set. Enable bit i covers data bits 8i+7 to 8i. A write with no enable set changes nothing.
- R5: Read-only bits are fixed by register index and are the same in every function:
  - index 0: all 32 bits;
  - odd indices: bits 31:24;
  - other even indices: mask 32'h0000_F0F0.
  A write without the override leaves these bits unchanged.
- R6: When `root_mode` is 1 and `req_dbg` is 1, a write also updates the read-only bits inside its enabled bytes.
- R7: When `root_mode` is 0, `req_dbg` has no effect, and read-only bits keep their value.
- R8: A strobe that is still high during the completion cycle does not start a second transaction.
- R9: A request is unmapped when its address is 16 or more or its function is 2 or more. An unmapped read completes with data zero. An unmapped write completes and modifies no register.
- R10: A read completes with the register value as it was before any write in that same completion. A write completes with read data zero. When both strobes are high, the request is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_mode | input | 1 | 1 = root-port mode, which allows the debug override |
| req_addr | input | 10 | Dword address of the register |
| req_func | input | 8 | Function number |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_dbg | input | 1 | Debug-access flag that comes with a write |
| rsp_rdata | output | 32 | Read data, valid while `rsp_done` is high |
| rsp_done | output | 1 | Single-cycle completion pulse |

## Verification
The bench keeps the strobe high through the completion cycle and then watches for several more cycles. A target that re-accepted the lingering strobe would emit a second, unrequested completion. It writes to aliasing out-of-range addresses such as 16, and to function 2, then reads the low registers back. A decoder that truncated the address or function would corrupt those registers. Debug-flagged writes are sent in both modes, with partial byte enables. This exposes an override that ignores the mode, ignores the byte enables, or never reaches the read-only bits. Every completion is also timed against LATENCY, so any off-by-one in the counter shows up.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

    localparam int ADDR_W = 10;
    localparam int FUNC_W = 8;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic              is_wr;
        logic              dbg;
        logic [ADDR_W-1:0] addr;
        logic [FUNC_W-1:0] func;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } txn_t;

    // Fixed read-only pattern of a register, chosen by its index inside a function
    function automatic logic [DATA_W-1:0] ro_mask(int unsigned idx);
        if (idx == 0)
            return '1;
        else if ((idx % 2) == 1)
            return 32'hFF00_0000;
        else
            return 32'h0000_F0F0;
    endfunction

    function automatic logic [DATA_W-1:0] reset_val(int unsigned fn, int unsigned idx);
        logic [7:0] hi;
        hi = 8'hC0 + 8'(fn);
        return {hi, 8'(idx), 16'hA5A5};
    endfunction

    function automatic logic [DATA_W-1:0] be_to_mask(logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++)
            m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/cfgt_ctrl.sv
module cfgt_ctrl
    import cfgt_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              dbg_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    output txn_t              txn_o,
    output logic              commit_o,
    output logic              done_o
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    state_e           state_q;
    logic [CNT_W-1:0] cnt_q;
    txn_t             txn_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            txn_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rd_i || wr_i) begin
                        txn_q.is_wr <= wr_i;
                        txn_q.dbg   <= dbg_i;
                        txn_q.addr  <= addr_i;
                        txn_q.func  <= func_i;
                        txn_q.wdata <= wdata_i;
                        txn_q.be    <= be_i;
                        cnt_q       <= CNT_W'(LATENCY - 1);
                        state_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                // completion cycle: a lingering strobe is the previous request
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign commit_o = (state_q == ST_WAIT) && (cnt_q == '0);
    assign txn_o    = txn_q;
    assign done_o   = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);                                           // R3
    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst)
        done_q |=> (state_q == ST_IDLE));                              // R8
    AST_TXN_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |=> $stable(txn_q));                     // R2

endmodule

// File: rtl/cfgt_decode.sv
module cfgt_decode
    import cfgt_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NFUNC = 2,
    parameter int SEL_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic              hit_o,
    output logic [SEL_W-1:0]  sel_o
);

    always_comb begin
        hit_o = (int'(addr_i) < NREG) && (int'(func_i) < NFUNC);
        sel_o = SEL_W'(int'(func_i) * NREG + int'(addr_i));
    end

endmodule

// File: rtl/cfgt_store.sv
module cfgt_store
    import cfgt_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NFUNC = 2,
    parameter int SEL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  txn_t              txn_i,
    input  logic              hit_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              root_mode_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int NTOT = NREG * NFUNC;

    logic [DATA_W-1:0] mem_q   [NTOT];
    logic [DATA_W-1:0] ro_tbl  [NTOT];
    logic [DATA_W-1:0] rst_tbl [NTOT];
    logic [DATA_W-1:0] rdata_q;

    for (genvar g = 0; g < NTOT; g++) begin : g_const
        assign ro_tbl[g]  = ro_mask(g % NREG);
        assign rst_tbl[g] = reset_val(g / NREG, g % NREG);
    end

    logic              override;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] cur_ro;
    logic [DATA_W-1:0] byte_bits;
    logic [DATA_W-1:0] wr_bits;
    logic [DATA_W-1:0] merged;
    logic              do_write;

    always_comb begin
        override  = root_mode_i && txn_i.dbg;
        cur_word  = hit_i ? mem_q[sel_i] : '0;
        cur_ro    = hit_i ? ro_tbl[sel_i] : '1;
        byte_bits = be_to_mask(txn_i.be);
        wr_bits   = byte_bits & (override ? '1 : ~cur_ro);
        merged    = (cur_word & ~wr_bits) | (txn_i.wdata & wr_bits);
        do_write  = commit_i && txn_i.is_wr && hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTOT; i++)
                mem_q[i] <= rst_tbl[i];
            rdata_q <= '0;
        end else if (commit_i) begin
            if (do_write)
                mem_q[sel_i] <= merged;
            rdata_q <= (!txn_i.is_wr && hit_i) ? cur_word : '0;
        end
    end

    assign rdata_o = rdata_q;

    AST_RO_KEPT: assert property (@(posedge clk) disable iff (rst)
        (do_write && !override) |=>
        (((mem_q[$past(sel_i)] ^ $past(cur_word)) & $past(cur_ro)) == '0));   // R5
    AST_BYTES_KEPT: assert property (@(posedge clk) disable iff (rst)
        do_write |=>
        (((mem_q[$past(sel_i)] ^ $past(cur_word)) & ~$past(byte_bits)) == '0)); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !hit_i) |=> (rdata_q == '0));                     // R9
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (commit_i && txn_i.is_wr) |=> (rdata_q == '0));                 // R10

endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
    import cfgt_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int NREG    = 16,
    parameter int NFUNC   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                root_mode,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [FUNC_W-1:0]   req_func,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [BE_W-1:0]     req_be,
    input  logic                req_rd,
    input  logic                req_wr,
    input  logic                req_dbg,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_done
);

    localparam int NTOT  = NREG * NFUNC;
    localparam int SEL_W = (NTOT > 1) ? $clog2(NTOT) : 1;

    txn_t             txn;
    logic             commit;
    logic             done;
    logic             hit;
    logic [SEL_W-1:0] sel;

    cfgt_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (req_rd),
        .wr_i     (req_wr),
        .dbg_i    (req_dbg),
        .addr_i   (req_addr),
        .func_i   (req_func),
        .wdata_i  (req_wdata),
        .be_i     (req_be),
        .txn_o    (txn),
        .commit_o (commit),
        .done_o   (done)
    );

    cfgt_decode #(.NREG(NREG), .NFUNC(NFUNC), .SEL_W(SEL_W)) u_decode (
        .addr_i (txn.addr),
        .func_i (txn.func),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    cfgt_store #(.NREG(NREG), .NFUNC(NFUNC), .SEL_W(SEL_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .txn_i       (txn),
        .hit_i       (hit),
        .sel_i       (sel),
        .root_mode_i (root_mode),
        .rdata_o     (rsp_rdata)
    );

    assign rsp_done = done;

    AST_DONE_LOW_AFTER_RST: assert property (@(posedge clk)
        $past(rst) |-> !rsp_done);                                     // R1

endmodule

// File: tb/cfg_space_target_tb.sv
module cfg_space_target_tb;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_mode = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [7:0]  req_func = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic        req_dbg = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_done;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [2][16];

    always #10 clk = ~clk;

    cfg_space_target #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst(rst), .root_mode(root_mode),
        .req_addr(req_addr), .req_func(req_func), .req_wdata(req_wdata),
        .req_be(req_be), .req_rd(req_rd), .req_wr(req_wr), .req_dbg(req_dbg),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
    );

    function automatic logic [31:0] exp_ro(int idx);
        if (idx == 0) return 32'hFFFF_FFFF;
        if (idx % 2 == 1) return 32'hFF00_0000;
        return 32'h0000_F0F0;
    endfunction

    function automatic logic [31:0] exp_reset(int fn, int idx);
        return {8'(8'hC0 + fn), 8'(idx), 16'hA5A5};
    endfunction

    function automatic logic [31:0] exp_merge(logic [31:0] old, logic [31:0] wd,
                                              logic [3:0] be, bit ovr, int idx);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
        if (!ovr) m = m & ~exp_ro(idx);
        return (old & ~m) | (wd & m);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic txn(bit wr, bit rd, bit dbg, bit root, int addr, int fn,
                       logic [31:0] wd, logic [3:0] be, string tag);
        bit mapped;
        logic [31:0] exp_rd;
        int cyc;
        bit extra;
        mapped = (addr < 16) && (fn < 2);
        exp_rd = (!wr && mapped) ? model[fn][addr] : 32'h0;
        cyc = 0;
        extra = 0;
        @(negedge clk);
        root_mode = root; req_addr = 10'(addr); req_func = 8'(fn);
        req_wdata = wd; req_be = be; req_dbg = dbg; req_rd = rd; req_wr = wr;
        do begin
            @(posedge clk); @(negedge clk); cyc++;
        end while (!rsp_done && cyc < 40);
        chk(cyc == LAT + 1, "R2", "completion cycle", 32'(cyc), 32'(LAT + 1));
        chk(rsp_rdata == exp_rd, tag, "read data", rsp_rdata, exp_rd);
        if (wr && mapped)
            model[fn][addr] = exp_merge(model[fn][addr], wd, be, root && dbg, addr);
        // strobe stays high through the completion cycle (R8)
        @(posedge clk); @(negedge clk);
        req_rd = 0; req_wr = 0; req_dbg = 0;
        chk(!rsp_done, "R3", "done width", 32'(rsp_done), 32'h0);
        for (int k = 0; k < LAT + 2; k++) begin
            @(posedge clk); @(negedge clk);
            if (rsp_done) extra = 1;
        end
        chk(!extra, "R8", "second completion", 32'(extra), 32'h0);
    endtask

    task automatic rd_chk(int addr, int fn, string tag);
        txn(0, 1, 0, 0, addr, fn, 32'h0, 4'h0, tag);
    endtask

    bit finished = 0;

    initial begin
        void'($urandom(32'd20240611));
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 16; r++)
                model[f][r] = exp_reset(f, r);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(!rsp_done, "R1", "done after reset", 32'(rsp_done), 32'h0);
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 16; r++)
                rd_chk(r, f, "R1");

        // R4 byte enables
        txn(1, 0, 0, 0, 4, 0, 32'hFFFF_FFFF, 4'b0101, "R10");
        rd_chk(4, 0, "R4");
        txn(1, 0, 0, 0, 6, 1, 32'h1234_5678, 4'b0000, "R10");
        rd_chk(6, 1, "R4");
        // R5 read-only kept
        txn(1, 0, 0, 1, 0, 0, 32'h0, 4'hF, "R10");
        rd_chk(0, 0, "R5");
        txn(1, 0, 0, 1, 3, 1, 32'h0000_0000, 4'hF, "R10");
        rd_chk(3, 1, "R5");
        // R6 override in root mode, partial enables
        txn(1, 0, 1, 1, 0, 0, 32'h1122_3344, 4'b0011, "R10");
        rd_chk(0, 0, "R6");
        txn(1, 0, 1, 1, 2, 1, 32'h0000_0000, 4'b0011, "R10");
        rd_chk(2, 1, "R6");
        // R7 debug flag ignored in endpoint mode
        txn(1, 0, 1, 0, 8, 0, 32'h0000_0000, 4'hF, "R10");
        rd_chk(8, 0, "R7");
        txn(1, 0, 1, 0, 0, 1, 32'hDEAD_BEEF, 4'hF, "R10");
        rd_chk(0, 1, "R7");
        // R9 unmapped
        txn(1, 0, 1, 1, 16, 0, 32'hAAAA_5555, 4'hF, "R9");
        txn(1, 0, 1, 1, 1, 2, 32'hAAAA_5555, 4'hF, "R9");
        txn(1, 0, 1, 1, 17, 1, 32'hAAAA_5555, 4'hF, "R9");
        rd_chk(0, 0, "R9");
        rd_chk(1, 0, "R9");
        rd_chk(1, 1, "R9");
        rd_chk(16, 0, "R9");
        rd_chk(5, 7, "R9");
        // R10 both strobes: write wins, data zero
        txn(1, 1, 0, 0, 5, 0, 32'h0F0F_0F0F, 4'hF, "R10");
        rd_chk(5, 0, "R10");

        // random traffic
        for (int n = 0; n < 250; n++) begin
            int kind;
            bit w;
            bit r;
            kind = int'($urandom() % 10);
            w = (kind < 5);
            r = (kind >= 4);
            txn(w, r, 1'($urandom()), 1'($urandom()), int'($urandom() % 20),
                int'($urandom() % 3), $urandom(), 4'($urandom()),
                w ? "R10" : "R9");
        end
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 16; r++)
                rd_chk(r, f, "R6");

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule